// File: doc/BRIEF.md
# Single-Clock FIFO with Quantized Fill and Free-Space Levels

This block is a first-in first-out buffer whose write and read sides run on one clock and one synchronous active-high reset. A producer offers a word with `put` and may do so whenever `full` is low. A consumer sees the oldest stored word on `dout` with `valid` high (first-word fall-through) and pulses `got` to take it, after which the next word, if any, is shown.

Besides the handshake flags, two coarse occupancy codes are produced combinationally from the difference of the write and read pointers. `fill_lvl` is a lower bound on how many words are stored; `free_lvl` is a lower bound on how many more words can be accepted. Each code has a configurable number of bits and rounds down, so it is never optimistic; it is meant for pacing decisions, never as a replacement for `full` or `valid`. A bit count of zero turns a code off. The requested depth is rounded up to a power of two (at least 2) and all level arithmetic uses that actual depth. Two build options register the full/empty flags and add an output register in front of `dout`.

Top module: `sfifo_lvl`

## Requirements
- R1: After reset the FIFO is empty: `valid` is 0, `full` is 0, `fill_lvl` is 0 and `free_lvl` is all ones (when enabled).
- R2: The usable depth D is the smallest power of two that is at least `MIN_DEPTH` and at least 2; `full` is 1 exactly when D words are held in storage.
- R3: `put` with `full` low stores `din`; `put` with `full` high and no read accepted in the same cycle is ignored and leaves contents and order unchanged.
- R4: The oldest word is shown on `dout` with `valid` high and stays stable until `got` is seen with `valid` high, which removes it; `got` with `valid` low has no effect.
- R5: A `put` and an accepted `got` in the same cycle both take effect and leave the word count unchanged, also when the FIFO is full (the write is accepted); when the FIFO is empty only the write takes effect.
- R6: With N = `FILL_BITS` > 0, `fill_lvl` (bit 0 is the LSB) equals min(floor(C·2^N/D), 2^N−1), where C is the number of stored words; N must not exceed log2(D).
- R7: With M = `FREE_BITS` > 0, `free_lvl` equals min(floor((D−C)·2^M/D), 2^M−1); M must not exceed log2(D).
- R8: Both level codes follow the word count without added delay: they are valid in the same cycle as the `full`/`valid` flags after the clock edge that changes C.
- R9: A level whose bit count is 0 is a single output bit held at 0.
- R10: With `REG_OUT` set, a word written into an empty FIFO shows `valid` two clock edges after the write edge instead of one, word order is unchanged, and C then counts only words in storage (not the one held in the output register); `REG_FLAGS` changes no visible timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both sides |
| rst | input | 1 | Synchronous active-high reset, empties the FIFO |
| put | input | 1 | Write request for `din` |
| din | input | DATA_W | Word to store |
| full | output | 1 | Storage holds D words |
| free_lvl | output | max(FREE_BITS,1) | Quantized guaranteed free space |
| got | input | 1 | Consumer takes the word on `dout` |
| dout | output | DATA_W | Oldest word |
| valid | output | 1 | `dout` holds a word |
| fill_lvl | output | max(FILL_BITS,1) | Quantized guaranteed occupancy |

## Verification
The assertions assume that reset is held for at least one clock edge before traffic starts and that `put`, `got` and `din` change only away from the rising edge, so the flags they rely on (`full`, `valid`, the stable head word) are settled when sampled. The bench drives all inputs at the falling edge and reads outputs one time unit later, and it deliberately offers `put` while `full` is high and `got` while `valid` is low, since those cases fall under the assumptions' allowed behaviour rather than outside it. On the registered-output build the stimulus only writes while `full` is low, so the producer never depends on a same-cycle read freeing a slot through the output register.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    // Full/empty pair carried between pointer logic and the output stage.
    typedef struct packed {
        logic full;
        logic empty;
    } sfifo_flags_t;

    // Smallest power of two that is at least n and at least 2.
    function automatic int unsigned pow2_ceil(input int unsigned n);
        int unsigned d;
        d = 2;
        while (d < n) d = d << 1;
        return d;
    endfunction

    // Output width of a level code: a disabled code still keeps one bit.
    function automatic int unsigned code_width(input int unsigned bits);
        return (bits == 0) ? 1 : bits;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 8,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wr_addr] <= wr_data;
    end

    // Asynchronous read gives the fall-through head word.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sfifo_ptrs.sv
module sfifo_ptrs
    import sfifo_pkg::*;
#(
    parameter int AW        = 3,
    parameter bit REG_FLAGS = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_req,
    input  logic         rd_req,
    output logic         wr_en,
    output logic         rd_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]  occ,
    output sfifo_flags_t flags
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    logic [AW:0] wp, rp;
    logic [AW:0] occ_next;

    assign occ     = wp - rp;
    assign wr_addr = wp[AW-1:0];
    assign rd_addr = rp[AW-1:0];

    // A read frees a slot in the same cycle, so a full FIFO still takes a write.
    always_comb begin
        rd_en = rd_req && !flags.empty;
        wr_en = wr_req && (!flags.full || rd_en);
    end

    assign occ_next = occ + (AW+1)'(wr_en) - (AW+1)'(rd_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
        end
    end

    generate
        if (REG_FLAGS) begin : g_flag_reg
            sfifo_flags_t flags_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    flags_q.full  <= 1'b0;
                    flags_q.empty <= 1'b1;
                end else begin
                    flags_q.full  <= (occ_next == DEPTH_V);
                    flags_q.empty <= (occ_next == '0);
                end
            end
            assign flags = flags_q;
        end else begin : g_flag_comb
            logic unused_next;
            assign unused_next = ^occ_next;
            assign flags.full  = (occ == DEPTH_V);
            assign flags.empty = (occ == '0);
        end
    endgenerate

endmodule

// File: rtl/sfifo_level.sv
module sfifo_level
    import sfifo_pkg::*;
#(
    parameter int AW    = 3,
    parameter int BITS  = 2,
    parameter bit FREE  = 1'b0
) (
    input  logic [AW:0]                 occ,
    output logic [code_width(BITS)-1:0] code
);
    localparam int DEPTH = 1 << AW;

    generate
        if (BITS == 0) begin : g_off
            logic unused_occ;
            assign unused_occ = ^occ;
            assign code = '0;
        end else begin : g_on
            localparam int SH   = AW - BITS;
            localparam int MAXC = (1 << BITS) - 1;
            logic [AW:0] amount;
            logic [AW:0] scaled;

            // Free space or occupancy, scaled by 2^BITS/DEPTH, rounded down.
            assign amount = FREE ? ((AW+1)'(DEPTH) - occ) : occ;
            assign scaled = amount >> SH;
            assign code   = (scaled > (AW+1)'(MAXC)) ? BITS'(MAXC)
                                                     : scaled[BITS-1:0];
        end
    endgenerate

endmodule

// File: rtl/sfifo_ostage.sv
module sfifo_ostage #(
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              got,
    input  logic              core_empty,
    input  logic              core_rd_en,
    input  logic [DATA_W-1:0] core_data,
    output logic              core_rd_req,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);
    generate
        if (REG_OUT) begin : g_reg
            logic              ov;
            logic [DATA_W-1:0] od;
            logic              unused_empty;

            assign unused_empty = core_empty;
            // Refill whenever the holding register is free or being emptied.
            assign core_rd_req  = !ov || got;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ov <= 1'b0;
                end else if (core_rd_en) begin
                    ov <= 1'b1;
                    od <= core_data;
                end else if (got) begin
                    ov <= 1'b0;
                end
            end

            assign valid = ov;
            assign dout  = od;
        end else begin : g_thru
            logic [2:0] unused_bits;
            assign unused_bits = {core_rd_en, clk, rst};
            assign core_rd_req = got;
            assign valid       = !core_empty;
            assign dout        = core_data;
        end
    endgenerate

endmodule

// File: rtl/sfifo_lvl.sv
module sfifo_lvl
    import sfifo_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MIN_DEPTH = 16,
    parameter int FILL_BITS = 2,
    parameter int FREE_BITS = 2,
    parameter bit REG_FLAGS = 1'b0,
    parameter bit REG_OUT   = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              put,
    input  logic [DATA_W-1:0]                 din,
    output logic                              full,
    output logic [code_width(FREE_BITS)-1:0]  free_lvl,
    input  logic                              got,
    output logic [DATA_W-1:0]                 dout,
    output logic                              valid,
    output logic [code_width(FILL_BITS)-1:0]  fill_lvl
);
    localparam int DEPTH = pow2_ceil(MIN_DEPTH);
    localparam int AW    = $clog2(DEPTH);

    logic              wr_en, rd_en, core_rd_req;
    logic [AW-1:0]     wr_addr, rd_addr;
    logic [AW:0]       occ;
    logic [DATA_W-1:0] head;
    sfifo_flags_t      flags;

    sfifo_ptrs #(.AW(AW), .REG_FLAGS(REG_FLAGS)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (put),
        .rd_req  (core_rd_req),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .occ     (occ),
        .flags   (flags)
    );

    sfifo_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk     (clk),
        .we      (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (head)
    );

    sfifo_ostage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_ostage (
        .clk         (clk),
        .rst         (rst),
        .got         (got),
        .core_empty  (flags.empty),
        .core_rd_en  (rd_en),
        .core_data   (head),
        .core_rd_req (core_rd_req),
        .valid       (valid),
        .dout        (dout)
    );

    sfifo_level #(.AW(AW), .BITS(FILL_BITS), .FREE(1'b0)) u_fill (
        .occ  (occ),
        .code (fill_lvl)
    );

    sfifo_level #(.AW(AW), .BITS(FREE_BITS), .FREE(1'b1)) u_free (
        .occ  (occ),
        .code (free_lvl)
    );

    assign full = flags.full;

endmodule

// File: rtl/sfifo_lvl_chk.sv
module sfifo_lvl_chk
    import sfifo_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int AW        = 3,
    parameter int FILL_BITS = 2,
    parameter int FREE_BITS = 2,
    parameter bit REG_OUT   = 1'b0
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              put,
    input logic                              got,
    input logic                              full,
    input logic                              valid,
    input logic [DATA_W-1:0]                 dout,
    input logic [code_width(FILL_BITS)-1:0]  fill_lvl,
    input logic [code_width(FREE_BITS)-1:0]  free_lvl,
    input logic [AW:0]                       occ
);
    localparam int DEPTH = 1 << AW;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid && !full));

    a_r2_full_at_depth: assert property (@(posedge clk) disable iff (rst)
        full |-> (occ == (AW+1)'(DEPTH)));

    a_r2_occ_bounded: assert property (@(posedge clk) disable iff (rst)
        occ <= (AW+1)'(DEPTH));

    a_r3_full_write_blocked: assert property (@(posedge clk) disable iff (rst)
        (full && !got) |=> full);

    a_r4_head_held: assert property (@(posedge clk) disable iff (rst)
        (valid && !got) |=> (valid && $stable(dout)));

    a_r4_full_has_head: assert property (@(posedge clk) disable iff (rst)
        full |-> valid);

    generate
        if (!REG_OUT) begin : g_swap
            a_r5_full_swap_keeps_full: assert property (@(posedge clk) disable iff (rst)
                (full && put && got) |=> full);
        end
        if (FILL_BITS > 0) begin : g_fill
            a_r6_fill_zero_when_empty: assert property (@(posedge clk) disable iff (rst)
                (occ == '0) |-> (fill_lvl == '0));
            a_r6_fill_top_when_full: assert property (@(posedge clk) disable iff (rst)
                full |-> (fill_lvl == '1));
        end
        if (FREE_BITS > 0) begin : g_free
            a_r7_free_zero_when_full: assert property (@(posedge clk) disable iff (rst)
                full |-> (free_lvl == '0));
            a_r7_free_top_when_empty: assert property (@(posedge clk) disable iff (rst)
                (occ == '0) |-> (free_lvl == '1));
        end
    endgenerate

endmodule

bind sfifo_lvl sfifo_lvl_chk #(
    .DATA_W    (DATA_W),
    .AW        (AW),
    .FILL_BITS (FILL_BITS),
    .FREE_BITS (FREE_BITS),
    .REG_OUT   (REG_OUT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .put      (put),
    .got      (got),
    .full     (full),
    .valid    (valid),
    .dout     (dout),
    .fill_lvl (fill_lvl),
    .free_lvl (free_lvl),
    .occ      (occ)
);

// File: tb/sim_sfifo_lvl.sv
module sim_sfifo_lvl;

    localparam int D0 = 8;   // MIN_DEPTH 5 rounds up to 8

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    // u0: depth 8, fill code 2 bits, free code 3 bits, registered flags
    logic       put = 0, got = 0, full, valid;
    logic [7:0] din = '0, dout;
    logic [1:0] fill_lvl;
    logic [2:0] free_lvl;

    // u1: depth 4, registered output, both codes disabled
    logic       put1 = 0, got1 = 0, full1, valid1;
    logic [7:0] din1 = '0, dout1;
    logic       fill1, free1;

    sfifo_lvl #(.DATA_W(8), .MIN_DEPTH(5), .FILL_BITS(2), .FREE_BITS(3),
                .REG_FLAGS(1'b1), .REG_OUT(1'b0)) u0 (
        .clk(clk), .rst(rst), .put(put), .din(din), .full(full),
        .free_lvl(free_lvl), .got(got), .dout(dout), .valid(valid),
        .fill_lvl(fill_lvl));

    sfifo_lvl #(.DATA_W(8), .MIN_DEPTH(4), .FILL_BITS(0), .FREE_BITS(0),
                .REG_FLAGS(1'b0), .REG_OUT(1'b1)) u1 (
        .clk(clk), .rst(rst), .put(put1), .din(din1), .full(full1),
        .free_lvl(free1), .got(got1), .dout(dout1), .valid(valid1),
        .fill_lvl(fill1));

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    logic [7:0] q[$];
    logic [7:0] q1[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_fill(input int c);
        int v = (c * 4) / D0;
        return (v > 3) ? 3 : v;
    endfunction

    function automatic int exp_free(input int c);
        int v = ((D0 - c) * 8) / D0;
        return (v > 7) ? 7 : v;
    endfunction

    // Called just after a falling edge; compares, then advances one clock.
    task automatic step(input bit p, input bit g, input logic [7:0] d);
        bit acc_g, acc_p;
        put = p; got = g; din = d;
        #1;
        chk("R4", "valid", int'(valid), int'(q.size() > 0));
        if (q.size() > 0) chk("R4", "dout", int'(dout), int'(q[0]));
        chk("R2", "full", int'(full), int'(q.size() == D0));
        chk("R6", "fill_lvl", int'(fill_lvl), exp_fill(q.size()));
        chk("R7", "free_lvl", int'(free_lvl), exp_free(q.size()));
        acc_g = g && (q.size() > 0);
        acc_p = p && ((q.size() < D0) || acc_g);   // R3, R5
        @(posedge clk);
        if (acc_g) void'(q.pop_front());
        if (acc_p) q.push_back(d);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; put = 0; got = 0; put1 = 0; got1 = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        q.delete();
        q1.delete();
        #1;
        chk("R1", "valid after reset", int'(valid), 0);
        chk("R1", "full after reset", int'(full), 0);
        chk("R1", "fill after reset", int'(fill_lvl), 0);
        chk("R1", "free after reset", int'(free_lvl), 7);
        chk("R1", "u1 valid after reset", int'(valid1), 0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        int pp[4] = '{80, 20, 50, 95};
        int gp[4] = '{20, 80, 50, 95};
        logic [7:0] seq;
        seq = 8'h10;

        do_reset();

        // R2/R6/R7/R8: fill to full one word at a time, every level visited
        for (int i = 0; i < D0; i++) begin step(1, 0, seq); seq++; end
        // R3: writes offered while full are dropped
        for (int i = 0; i < 3; i++) begin step(1, 0, 8'hEE); end
        // R5: write and read together while full
        step(1, 1, seq); seq++;
        step(1, 1, seq); seq++;
        // drain, R4 ordering
        for (int i = 0; i < D0; i++) step(0, 1, 8'h00);
        // R4: read while empty ignored; R5: write+read while empty stores only
        step(0, 1, 8'h00);
        step(1, 1, 8'hA5);
        step(0, 0, 8'h00);
        step(0, 1, 8'h00);
        step(0, 0, 8'h00);

        // Sweeps under four traffic mixes
        for (int ph = 0; ph < 4; ph++) begin
            for (int n = 0; n < 1500; n++) begin
                step(($urandom % 100) < pp[ph], ($urandom % 100) < gp[ph], 8'($urandom));
            end
        end

        // R1: reset in the middle of traffic
        for (int i = 0; i < 5; i++) begin step(1, 0, seq); seq++; end
        do_reset();
        step(0, 0, 8'h00);

        // R10: registered output latency on u1
        put1 = 1; din1 = 8'h3C;
        @(posedge clk); @(negedge clk);
        put1 = 0;
        #1;
        chk("R10", "u1 valid one edge after write", int'(valid1), 0);
        @(negedge clk); #1;
        chk("R10", "u1 valid two edges after write", int'(valid1), 1);
        chk("R10", "u1 first word", int'(dout1), 'h3C);
        got1 = 1;
        @(posedge clk); @(negedge clk);
        got1 = 0;

        // R10/R9: ordered stream through the registered output
        seq = 8'h00;
        for (int n = 0; n < 2000; n++) begin
            bit pw, gr;
            pw = ((($urandom % 100) < 60) && !full1);
            gr = (($urandom % 100) < 55);
            put1 = pw; got1 = gr; din1 = seq;
            #1;
            chk("R9", "u1 fill tied off", int'(fill1), 0);
            chk("R9", "u1 free tied off", int'(free1), 0);
            if (valid1 && gr) begin
                if (q1.size() == 0) chk("R10", "u1 spurious word", 1, 0);
                else chk("R10", "u1 order", int'(dout1), int'(q1.pop_front()));
            end
            if (pw) begin q1.push_back(seq); seq++; end
            @(posedge clk); @(negedge clk);
        end
        put1 = 0;
        for (int n = 0; n < 20; n++) begin
            got1 = 1;
            #1;
            if (valid1) begin
                if (q1.size() == 0) chk("R10", "u1 spurious word", 1, 0);
                else chk("R10", "u1 order drain", int'(dout1), int'(q1.pop_front()));
            end
            @(posedge clk); @(negedge clk);
        end
        got1 = 0;
        chk("R10", "u1 words left", q1.size(), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule